// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Monitor

This block sits behind a serial receiver. It takes one recovered bit per clock enable and finds the word boundary of an 18-bit framed stream. Each frame carries a 16-bit payload. The boundary is marked by a rising transition at the start of each frame. The block searches arbitrary incoming data for that transition. It confirms the transition at a fixed bit offset over several frames, then declares lock and hands out each payload as a parallel word with a one-cycle strobe.

While locked, the block tolerates one frame with a missing start transition. A second consecutive miss drops lock, raises a sticky loss-of-lock status and an optional interrupt, and starts the search again. A powerdown request idles the block. Every exit from powerdown passes through a timed initialization period before the search begins. A fast-sync request shortens the lock qualification to a single frame. The active-low lock output can be wired straight back to the fast-sync request.

Top module: `eclk_lock_mon`

## Requirements
- R1: A frame is 18 bits in this order: a start bit of 1, 16 payload bits with bit 0 first, and a stop bit of 0. While locked, `word_out` takes the payload and `word_vld` pulses for one clock in the cycle after the last payload bit is taken.
- R2: Lock (`lock_n` low) is declared at the start bit of the 4th consecutive frame whose 0-to-1 start transition falls at the same bit offset. After only three such frames `lock_n` is still high.
- R3: While searching, each bit position without a start transition moves the candidate offset by one bit, and a mismatch restarts the frame count. A false edge in leading junk data must therefore not shorten the 4-frame qualification.
- R4: While locked, a single frame without its start transition keeps lock. A frame whose transition is present resets the miss count.
- R5: Two consecutive frames without a start transition drop lock. The block returns to searching and needs 4 matching frames to lock again.
- R6: `lock_n` is active low. `word_vld` is asserted only while locked, so no word is flagged valid while unlocked.
- R7: `los_status` goes high when lock is lost and stays high, across relock, until a one-cycle `los_clr` pulse clears it. A new loss in the same cycle wins over the clear.
- R8: `irq` equals `los_status` AND `irq_en`.
- R9: Powerdown is requested when `pwdn_n` is low or `pwdn_reg` is high. The next cycle `lock_n` is high. From the cycle after that, `word_out` is 0 and `word_vld` stays low, regardless of the incoming bits.
- R10: Leaving powerdown enters initialization for INIT_FRAMES (default 64) frame periods of 18 bit enables each, starting at the first bit enable after exit. Only then does the search begin, so lock takes at least INIT_FRAMES+4 frames.
- R11: With `sync_req` high during the search, a single start transition declares lock.
- R12: While reset is asserted, `lock_n` is 1 and `word_vld`, `word_out`, `los_status` and `irq` are 0. Release of reset is treated as an exit from powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Clock enable: one serial bit is taken per enabled cycle |
| ser_in | input | 1 | Serial data bit |
| pwdn_n | input | 1 | Powerdown pin, low requests powerdown |
| pwdn_reg | input | 1 | Powerdown control bit, high requests powerdown |
| sync_req | input | 1 | Fast-sync request, single-frame lock qualification |
| irq_en | input | 1 | Interrupt enable for loss of lock |
| los_clr | input | 1 | Write-one-to-clear pulse for `los_status` |
| lock_n | output | 1 | Lock indication, low when output words are valid |
| word_out | output | 16 | Last delivered payload word |
| word_vld | output | 1 | One-cycle strobe for a valid word |
| los_status | output | 1 | Sticky loss-of-lock status |
| irq | output | 1 | Loss-of-lock interrupt |

## Verification
The bench sends leading junk that contains a false rising edge. A search that does not restart its frame count after a mismatch would lock one frame early, and the bench would see that. It inserts a single missed frame twice with a good frame between them. A design that drops lock on the first miss, or that never clears its miss count, would then lose lock. The bench counts exact frame numbers after a powerdown exit, so a block that skips initialization would lock 64 frames too early. It also checks that no word is strobed while unlocked or powered down, and that the loss status survives relock until it is cleared.

// File: rtl/eclk_lock_pkg.sv
package eclk_lock_pkg;
  typedef enum logic [1:0] {
    LM_PWDN = 2'd0,
    LM_INIT = 2'd1,
    LM_HUNT = 2'd2,
    LM_LOCK = 2'd3
  } lm_state_e;
endpackage

// File: rtl/eclk_bit_phase.sv
module eclk_bit_phase #(
  parameter int FRAME_BITS = 18,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [POS_W-1:0] pos_o,
  output logic             at_start_o,
  output logic             at_last_o
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  assign at_start_o = (pos_q == '0);
  assign at_last_o  = (pos_q == POS_LAST);
  assign pos_o      = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (clr_i) begin
      pos_d = '0;
    end else if (tick_i && !hold_i) begin
      pos_d = at_last_o ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);

  // R1
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i && !hold_i && at_last_o) |=> (pos_q == '0));
endmodule

// File: rtl/eclk_deframer.sv
module eclk_deframer #(
  parameter int PAYLOAD_W = 16,
  parameter int POS_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 idle_i,
  input  logic                 deliver_i,
  input  logic [POS_W-1:0]     pos_i,
  input  logic                 bit_i,
  output logic                 edge_o,
  output logic [PAYLOAD_W-1:0] word_o,
  output logic                 vld_o
);
  logic                 prev_q, prev_d;
  logic [PAYLOAD_W-1:0] sh_q, sh_d;
  logic [PAYLOAD_W-1:0] word_q, word_d;
  logic                 vld_q, vld_d;
  logic                 in_pay, last_pay;

  assign edge_o   = !prev_q && bit_i;
  assign in_pay   = (pos_i >= POS_W'(1)) && (pos_i <= POS_W'(PAYLOAD_W));
  assign last_pay = tick_i && (pos_i == POS_W'(PAYLOAD_W));

  always_comb begin
    prev_d = tick_i ? bit_i : prev_q;
    sh_d   = (tick_i && in_pay) ? {bit_i, sh_q[PAYLOAD_W-1:1]} : sh_q;
    word_d = (last_pay && deliver_i) ? {bit_i, sh_q[PAYLOAD_W-1:1]} : word_q;
    vld_d  = last_pay && deliver_i;
    if (idle_i) begin
      prev_d = 1'b0;
      sh_d   = '0;
      word_d = '0;
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R6
  vld_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(deliver_i));

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_o && !$past(idle_i)) |-> $stable(word_o));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> ((word_o == '0) && !vld_o));
endmodule

// File: rtl/eclk_lock_fsm.sv
module eclk_lock_fsm
  import eclk_lock_pkg::*;
#(
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_FRAMES = 2,
  parameter int INIT_FRAMES = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      at_start_i,
  input  logic      at_last_i,
  input  logic      edge_i,
  input  logic      pwdn_n_i,
  input  logic      pwdn_reg_i,
  input  logic      sync_req_i,
  input  logic      irq_en_i,
  input  logic      los_clr_i,
  output lm_state_e state_o,
  output logic      pos_clr_o,
  output logic      pos_hold_o,
  output logic      los_o,
  output logic      irq_o
);
  localparam int MATCH_W = $clog2(LOCK_FRAMES + 1);
  localparam int MISS_W  = $clog2(MISS_FRAMES + 1);
  localparam int FRM_W   = $clog2(INIT_FRAMES + 2);
  localparam logic [MATCH_W-1:0] MATCH_LAST = MATCH_W'(LOCK_FRAMES - 1);
  localparam logic [MISS_W-1:0]  MISS_LAST  = MISS_W'(MISS_FRAMES - 1);
  localparam logic [FRM_W-1:0]   INIT_LAST  = FRM_W'((INIT_FRAMES > 0) ? INIT_FRAMES - 1 : 0);

  lm_state_e          state_q, state_d;
  logic [MATCH_W-1:0] match_q, match_d;
  logic [MISS_W-1:0]  miss_q, miss_d;
  logic [FRM_W-1:0]   frm_q, frm_d;
  logic               los_q, los_d, los_set;
  logic               pd, chk_slot;

  assign pd       = !pwdn_n_i || pwdn_reg_i;
  assign chk_slot = tick_i && at_start_i;

  always_comb begin
    state_d = state_q;
    match_d = match_q;
    miss_d  = miss_q;
    frm_d   = frm_q;
    los_set = 1'b0;
    unique case (state_q)
      LM_PWDN: begin
        frm_d = '0;
        if (!pd) state_d = LM_INIT;
      end
      LM_INIT: begin
        if (tick_i && at_last_i) begin
          if (frm_q >= INIT_LAST) begin
            state_d = LM_HUNT;
            match_d = '0;
          end else begin
            frm_d = frm_q + 1'b1;
          end
        end
      end
      LM_HUNT: begin
        if (chk_slot) begin
          if (!edge_i) begin
            match_d = '0;
          end else if (sync_req_i || match_q == MATCH_LAST) begin
            state_d = LM_LOCK;
            miss_d  = '0;
          end else begin
            match_d = match_q + 1'b1;
          end
        end
      end
      LM_LOCK: begin
        if (chk_slot) begin
          if (edge_i) begin
            miss_d = '0;
          end else if (miss_q == MISS_LAST) begin
            state_d = LM_HUNT;
            match_d = '0;
            los_set = 1'b1;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: state_d = LM_PWDN;
    endcase
    if (pd) state_d = LM_PWDN;
    los_d = los_set ? 1'b1 : (los_clr_i ? 1'b0 : los_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LM_PWDN;
      match_q <= '0;
      miss_q  <= '0;
      frm_q   <= '0;
      los_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      match_q <= match_d;
      miss_q  <= miss_d;
      frm_q   <= frm_d;
      los_q   <= los_d;
    end
  end

  assign state_o    = state_q;
  assign pos_clr_o  = (state_q == LM_PWDN);
  assign pos_hold_o = chk_slot && !edge_i &&
                      ((state_q == LM_HUNT) || (state_q == LM_LOCK && miss_q == MISS_LAST));
  assign los_o      = los_q;
  assign irq_o      = los_q && irq_en_i;

  // R4
  single_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LM_LOCK && !pd && chk_slot && !edge_i && miss_q != MISS_LAST)
      |=> (state_q == LM_LOCK));

  // R10
  init_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LM_INIT) |=> (state_q != LM_LOCK));

  // R7
  los_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los_q && !los_clr_i) |=> los_q);

  // R5
  loss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LM_HUNT && $past(state_q) == LM_LOCK) |-> los_q);

  // R9
  pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (state_q == LM_PWDN));
endmodule

// File: rtl/eclk_lock_mon.sv
module eclk_lock_mon
  import eclk_lock_pkg::*;
#(
  parameter int PAYLOAD_W   = 16,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_FRAMES = 2,
  parameter int INIT_FRAMES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 ser_in,
  input  logic                 pwdn_n,
  input  logic                 pwdn_reg,
  input  logic                 sync_req,
  input  logic                 irq_en,
  input  logic                 los_clr,
  output logic                 lock_n,
  output logic [PAYLOAD_W-1:0] word_out,
  output logic                 word_vld,
  output logic                 los_status,
  output logic                 irq
);
  localparam int FRAME_BITS = PAYLOAD_W + 2;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic [POS_W-1:0] pos;
  logic             at_start, at_last, pos_clr, pos_hold, edge_seen;
  lm_state_e        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  eclk_bit_phase #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tick_i     (bit_en),
    .clr_i      (pos_clr),
    .hold_i     (pos_hold),
    .pos_o      (pos),
    .at_start_o (at_start),
    .at_last_o  (at_last)
  );

  eclk_deframer #(.PAYLOAD_W(PAYLOAD_W), .POS_W(POS_W)) u_deframe (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick_i    (bit_en),
    .idle_i    (state == LM_PWDN),
    .deliver_i (state == LM_LOCK),
    .pos_i     (pos),
    .bit_i     (ser_in),
    .edge_o    (edge_seen),
    .word_o    (word_out),
    .vld_o     (word_vld)
  );

  eclk_lock_fsm #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .MISS_FRAMES (MISS_FRAMES),
    .INIT_FRAMES (INIT_FRAMES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tick_i     (bit_en),
    .at_start_i (at_start),
    .at_last_i  (at_last),
    .edge_i     (edge_seen),
    .pwdn_n_i   (pwdn_n),
    .pwdn_reg_i (pwdn_reg),
    .sync_req_i (sync_req),
    .irq_en_i   (irq_en),
    .los_clr_i  (los_clr),
    .state_o    (state),
    .pos_clr_o  (pos_clr),
    .pos_hold_o (pos_hold),
    .los_o      (los_status),
    .irq_o      (irq)
  );

  assign lock_n = (state != LM_LOCK);

  // R9
  pd_lock_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!pwdn_n || pwdn_reg) |=> lock_n);

  // R6
  vld_lock_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_vld |-> !$past(lock_n));
endmodule

// File: tb/eclk_lock_mon_bench.sv
module eclk_lock_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, ser_in, pwdn_n, pwdn_reg, sync_req, irq_en, los_clr;
  logic        lock_n, word_vld, los_status, irq;
  logic [15:0] word_out;

  int          n_chk = 0;
  int          n_fail = 0;
  int          vld_cnt = 0;
  int          snap;
  logic [15:0] last_word = '0;
  bit          done = 1'b0;

  localparam logic [15:0] TBL [6] = '{16'h0001, 16'h8000, 16'hA5C3,
                                      16'hFFFF, 16'h1234, 16'h0F0F};

  always #4 clk = ~clk;

  eclk_lock_mon u_eclk_lock_mon (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .pwdn_n(pwdn_n), .pwdn_reg(pwdn_reg), .sync_req(sync_req),
    .irq_en(irq_en), .los_clr(los_clr), .lock_n(lock_n),
    .word_out(word_out), .word_vld(word_vld), .los_status(los_status), .irq(irq)
  );

  always @(negedge clk) begin
    if (word_vld) begin
      vld_cnt   <= vld_cnt + 1;
      last_word <= word_out;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    bit_en = 1'b1;
  endtask

  task automatic send_frame(input logic [15:0] pl, input logic st);
    send_bit(st);
    for (int i = 0; i < 16; i++) send_bit(pl[i]);
    send_bit(1'b0);
  endtask

  task automatic pause();
    @(negedge clk);
    bit_en = 1'b0;
    ser_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0; pwdn_n = 1'b1; pwdn_reg = 1'b0;
    sync_req = 1'b0; irq_en = 1'b0; los_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 lock_n", lock_n, 1);
    chk("R12 word_vld/word_out/los/irq", {word_vld, word_out, los_status, irq}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 1300; i++) send_bit(1'b0);
    pause();
    chk("R10 no lock on idle after init", lock_n, 1);
    for (int i = 0; i < 3; i++) send_frame(16'h0000, 1'b1);
    pause();
    chk("R2 three frames not enough", lock_n, 1);
    chk("R6 no words strobed unlocked", vld_cnt, 0);
    send_frame(16'h0000, 1'b1);
    pause();
    chk("R2 lock on fourth frame", lock_n, 0);
    chk("R6 locked frame word strobed", vld_cnt, 1);

    // R1 payload vectors walked through the table
    for (int i = 0; i < 6; i++) begin
      snap = vld_cnt;
      send_frame(TBL[i], 1'b1);
      pause();
      chk("R1 word value", last_word, TBL[i]);
      chk("R1 one strobe per frame", vld_cnt - snap, 1);
    end

    // R4 isolated misses keep lock
    send_frame(16'h0000, 1'b0);
    pause();
    chk("R4 single miss keeps lock", lock_n, 0);
    send_frame(16'h5555, 1'b1);
    send_frame(16'h0000, 1'b0);
    pause();
    chk("R4 miss count reset by good frame", lock_n, 0);
    send_frame(16'h3C3C, 1'b1);
    pause();
    chk("R4 word after miss", last_word, 16'h3C3C);
    chk("R7 no loss yet", los_status, 0);

    // R5 two consecutive misses
    irq_en = 1'b1;
    send_frame(16'h0000, 1'b0);
    send_frame(16'h0000, 1'b0);
    pause();
    chk("R5 lock dropped", lock_n, 1);
    chk("R7 loss status set", los_status, 1);
    chk("R8 irq enabled", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R8 irq masked", irq, 0);
    snap = vld_cnt;
    for (int i = 0; i < 3; i++) send_frame(16'h0000, 1'b1);
    pause();
    chk("R5 relock needs four frames", lock_n, 1);
    chk("R6 no strobe while hunting", vld_cnt - snap, 0);
    send_frame(16'hBEEF, 1'b1);
    pause();
    chk("R5 relocked", lock_n, 0);
    chk("R7 status sticky across relock", los_status, 1);
    los_clr = 1'b1;
    @(negedge clk);
    los_clr = 1'b0;
    @(negedge clk);
    chk("R7 write-one-to-clear", los_status, 0);

    // R3 hunt through junk with a false edge
    send_frame(16'h0000, 1'b0);
    send_frame(16'h0000, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    for (int i = 0; i < 4; i++) send_frame(16'h0000, 1'b1);
    pause();
    chk("R3 false edge does not count", lock_n, 1);
    send_frame(16'h0000, 1'b1);
    pause();
    chk("R3 lock after sliding", lock_n, 0);

    // R11 fast synchronization
    send_frame(16'h0000, 1'b0);
    send_frame(16'h0000, 1'b0);
    pause();
    chk("R11 unlocked before fast sync", lock_n, 1);
    sync_req = 1'b1;
    send_frame(16'h6A6A, 1'b1);
    pause();
    sync_req = 1'b0;
    chk("R11 single-frame lock", lock_n, 0);
    chk("R11 word after fast sync", last_word, 16'h6A6A);

    // R9 powerdown by register bit
    @(negedge clk);
    pwdn_reg = 1'b1;
    snap = vld_cnt;
    send_frame(16'h1111, 1'b1);
    send_frame(16'h2222, 1'b1);
    pause();
    chk("R9 reg powerdown lock_n", lock_n, 1);
    chk("R9 reg powerdown word idle", word_out, 0);
    chk("R9 no strobe in powerdown", vld_cnt - snap, 0);

    // R10 exit passes through initialization
    pwdn_reg = 1'b0;
    for (int i = 0; i < 67; i++) send_frame(16'h0000, 1'b1);
    pause();
    chk("R10 init holds off lock", lock_n, 1);
    send_frame(16'h7E7E, 1'b1);
    pause();
    chk("R10 lock after init plus four", lock_n, 0);
    chk("R10 word after init", last_word, 16'h7E7E);

    // R9 powerdown by pin
    pwdn_n = 1'b0;
    send_frame(16'h3333, 1'b1);
    pause();
    chk("R9 pin powerdown lock_n", lock_n, 1);
    chk("R9 pin powerdown word idle", {word_vld, word_out}, 0);
    pwdn_n = 1'b1;
    pause();

    finish_run();
  end
endmodule